// File: doc/BRIEF.md
# Dual-Edge Input Capture Register

This block takes one serial data line and samples it on both edges of its clock. The rising-edge sample is presented on `q_rise_o` and the falling-edge sample on `q_fall_o`. Both outputs are single-rate signals, so logic clocked on the rising edge alone can consume two bits per clock period.

A parameter chooses how the two outputs line up in time:
- **Split alignment**: each output changes on its own edge.
- **Rising alignment**: both outputs change on the rising edge.
- **Pipelined rising alignment**: both outputs change on the rising edge and carry a matched rising/falling pair, at the cost of one extra cycle of latency.

Other parameters set the power-up value of each output and choose whether clear and preset act at once or only on the clock edge. A clock enable freezes every stage of the block.

Top module: `ddr_in_capture`

## Requirements
- R1: In split alignment (`ALIGN = ALIGN_SPLIT`, the default), `q_rise_o` takes the value of `d_i` sampled at a rising edge where `en_i` is high, and changes only at rising edges.
- R2: In split alignment, `q_fall_o` takes the value of `d_i` sampled at a falling edge where `en_i` is high, and changes only at falling edges.
- R3: `clr_i` is active high and drives every stage, and so both outputs, to 0. It has priority over `pre_i` when both are high.
- R4: `pre_i` is active high. When `clr_i` is low, it drives every stage, and so both outputs, to 1.
- R5: While `en_i` is low and neither `clr_i` nor `pre_i` is high, no stage loads, and both outputs hold their values across clock edges.
- R6: With `ASYNC_SR = 0` (the default), clear and preset act on each stage only at that stage's active clock edge. With `ASYNC_SR = 1`, they act on every stage as soon as they are asserted, with no clock edge needed.
- R7: Before any clock edge or clear/preset, `q_rise_o` equals `RISE_INIT` and `q_fall_o` equals `FALL_INIT`. Both default to 0.
- R8: In rising alignment (`ALIGN_RISE`), both outputs change only at rising edges. At a rising edge with `en_i` high, `q_fall_o` takes the falling-edge sample taken half a cycle earlier.
- R9: In pipelined rising alignment (`ALIGN_RISE_PIPE`), `q_fall_o` behaves as in R8. At a rising edge with `en_i` high, `q_rise_o` takes the rising-edge sample from the previous rising edge. The pair shown is therefore a rising sample and the falling sample that followed it.
- R10: Clear and preset take effect whether `en_i` is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Capture clock; both edges are used |
| en_i | input | 1 | Clock enable for every stage, active high |
| d_i | input | 1 | Serial data input |
| clr_i | input | 1 | Clear to 0, active high, wins over preset |
| pre_i | input | 1 | Preset to 1, active high |
| q_rise_o | output | 1 | Rising-edge sample |
| q_fall_o | output | 1 | Falling-edge sample |

## Verification
The assertions assume two things about the inputs:
- Every input changes well away from both clock edges.
- Once raised, clear or preset stays high across at least one rising edge and one falling edge, so every stage sees it at its own edge before it drops.

In asynchronous mode, the assertions also assume that clear is never released while preset stays high. The stimulus meets all three assumptions:
- Data and enable change a quarter period after each edge.
- Clear and preset change only a quarter period after a rising edge, and then hold for a full period.
- A preset-only request that would follow an active clear is turned into no request.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
  typedef enum logic [1:0] {
    ALIGN_SPLIT     = 2'd0,
    ALIGN_RISE      = 2'd1,
    ALIGN_RISE_PIPE = 2'd2
  } align_e;
endpackage

// File: rtl/ddr_cap_stage.sv
module ddr_cap_stage #(
  parameter bit FALLING  = 1'b0,
  parameter bit ASYNC_SR = 1'b0,
  parameter bit INIT     = 1'b0
) (
  input  logic clk_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic pre_i,
  input  logic d_i,
  output logic q_o
);
  logic clk_act;
  logic q_q = INIT;

  assign clk_act = FALLING ? ~clk_i : clk_i;
  assign q_o     = q_q;

  generate
    if (ASYNC_SR) begin : g_async
      always_ff @(posedge clk_act or posedge clr_i or posedge pre_i) begin
        if (clr_i)      q_q <= 1'b0;
        else if (pre_i) q_q <= 1'b1;
        else if (en_i)  q_q <= d_i;
      end
    end else begin : g_sync
      always_ff @(posedge clk_act) begin
        if (clr_i)      q_q <= 1'b0;
        else if (pre_i) q_q <= 1'b1;
        else if (en_i)  q_q <= d_i;
      end
    end
  endgenerate

  // R1/R2: an enabled edge loads the sampled data
  a_r1_load: assert property (@(posedge clk_act) disable iff (clr_i || pre_i)
    (en_i && !clr_i && !pre_i) |=> q_q == $past(d_i));
  // R5: disabled edges leave the stage alone
  a_r5_hold: assert property (@(posedge clk_act) disable iff (clr_i || pre_i)
    (!en_i && !clr_i && !pre_i) |=> $stable(q_q));
  // R3/R10: clear wins, enable irrelevant
  a_r3_clear: assert property (@(posedge clk_act) clr_i |=> !q_q);
  // R4/R10
  a_r4_preset: assert property (@(posedge clk_act) disable iff (clr_i)
    pre_i |=> q_q);
endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
  import ddr_cap_pkg::*;
#(
  parameter align_e ALIGN     = ALIGN_SPLIT,
  parameter bit     RISE_INIT = 1'b0,
  parameter bit     FALL_INIT = 1'b0,
  parameter bit     ASYNC_SR  = 1'b0
) (
  input  logic clk_i,
  input  logic en_i,
  input  logic d_i,
  input  logic clr_i,
  input  logic pre_i,
  output logic q_rise_o,
  output logic q_fall_o
);
  localparam bit REALIGN = (ALIGN != ALIGN_SPLIT);
  localparam bit PIPE    = (ALIGN == ALIGN_RISE_PIPE);

  logic rise_q;
  logic fall_q;

  ddr_cap_stage #(.FALLING(1'b0), .ASYNC_SR(ASYNC_SR), .INIT(PIPE ? 1'b0 : RISE_INIT)) u_rise (
    .clk_i(clk_i), .en_i(en_i), .clr_i(clr_i), .pre_i(pre_i), .d_i(d_i), .q_o(rise_q));

  ddr_cap_stage #(.FALLING(1'b1), .ASYNC_SR(ASYNC_SR), .INIT(FALL_INIT)) u_fall (
    .clk_i(clk_i), .en_i(en_i), .clr_i(clr_i), .pre_i(pre_i), .d_i(d_i), .q_o(fall_q));

  generate
    if (REALIGN) begin : g_realign
      // move the falling sample into the rising domain
      ddr_cap_stage #(.FALLING(1'b0), .ASYNC_SR(ASYNC_SR), .INIT(FALL_INIT)) u_fall_al (
        .clk_i(clk_i), .en_i(en_i), .clr_i(clr_i), .pre_i(pre_i), .d_i(fall_q), .q_o(q_fall_o));

      // R8: falling sample appears at the next rising edge
      a_r8_fall_realign: assert property (@(posedge clk_i) disable iff (clr_i || pre_i)
        (en_i && !clr_i && !pre_i) |=> q_fall_o == $past(fall_q));
    end else begin : g_split
      assign q_fall_o = fall_q;
    end

    if (PIPE) begin : g_pipe
      // delay the rising sample so it pairs with the following falling one
      ddr_cap_stage #(.FALLING(1'b0), .ASYNC_SR(ASYNC_SR), .INIT(RISE_INIT)) u_rise_pl (
        .clk_i(clk_i), .en_i(en_i), .clr_i(clr_i), .pre_i(pre_i), .d_i(rise_q), .q_o(q_rise_o));

      // R9: rising output lags the capture stage by one enabled edge
      a_r9_rise_delay: assert property (@(posedge clk_i) disable iff (clr_i || pre_i)
        (en_i && !clr_i && !pre_i) |=> q_rise_o == $past(rise_q));
    end else begin : g_direct
      assign q_rise_o = rise_q;
    end
  endgenerate
endmodule

// File: tb/ddr_in_capture_test.sv
module ddr_in_capture_test;
  import ddr_cap_pkg::*;

  logic clk = 1'b0;
  logic en  = 1'b0;
  logic d   = 1'b0;
  logic clr = 1'b0;
  logic pre = 1'b0;
  logic q1 [4];
  logic q2 [4];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // 0: split/sync 0,0  1: rise/sync 1,0  2: pipe/async 0,1  3: split/async 1,1
  ddr_in_capture uut (
    .clk_i(clk), .en_i(en), .d_i(d), .clr_i(clr), .pre_i(pre),
    .q_rise_o(q1[0]), .q_fall_o(q2[0]));
  ddr_in_capture #(.ALIGN(ALIGN_RISE), .RISE_INIT(1'b1), .FALL_INIT(1'b0), .ASYNC_SR(1'b0)) uut_rise (
    .clk_i(clk), .en_i(en), .d_i(d), .clr_i(clr), .pre_i(pre),
    .q_rise_o(q1[1]), .q_fall_o(q2[1]));
  ddr_in_capture #(.ALIGN(ALIGN_RISE_PIPE), .RISE_INIT(1'b0), .FALL_INIT(1'b1), .ASYNC_SR(1'b1)) uut_pipe (
    .clk_i(clk), .en_i(en), .d_i(d), .clr_i(clr), .pre_i(pre),
    .q_rise_o(q1[2]), .q_fall_o(q2[2]));
  ddr_in_capture #(.ALIGN(ALIGN_SPLIT), .RISE_INIT(1'b1), .FALL_INIT(1'b1), .ASYNC_SR(1'b1)) uut_async (
    .clk_i(clk), .en_i(en), .d_i(d), .clr_i(clr), .pre_i(pre),
    .q_rise_o(q1[3]), .q_fall_o(q2[3]));

  int mode  [4] = '{0, 1, 2, 0};
  bit asy   [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
  bit init1 [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
  bit init2 [4] = '{1'b0, 1'b0, 1'b1, 1'b1};

  // reference: latest rising sample, latest falling sample,
  // falling sample seen at last rising load, rising sample one load back
  bit last_rise [4];
  bit last_fall [4];
  bit fall_seen [4];
  bit rise_prev [4];

  function automatic bit exp_q1(int i);
    return (mode[i] == 2) ? rise_prev[i] : last_rise[i];
  endfunction

  function automatic bit exp_q2(int i);
    return (mode[i] == 0) ? last_fall[i] : fall_seen[i];
  endfunction

  task automatic model_force();
    for (int i = 0; i < 4; i++) begin
      if (asy[i] && clr) begin
        last_rise[i] = 0; last_fall[i] = 0; fall_seen[i] = 0; rise_prev[i] = 0;
      end else if (asy[i] && pre) begin
        last_rise[i] = 1; last_fall[i] = 1; fall_seen[i] = 1; rise_prev[i] = 1;
      end
    end
  endtask

  task automatic model_edge(input bit rising);
    for (int i = 0; i < 4; i++) begin
      if (rising) begin
        if (clr) begin
          last_rise[i] = 0; fall_seen[i] = 0; rise_prev[i] = 0;
        end else if (pre) begin
          last_rise[i] = 1; fall_seen[i] = 1; rise_prev[i] = 1;
        end else if (en) begin
          rise_prev[i] = last_rise[i];
          fall_seen[i] = last_fall[i];
          last_rise[i] = d;
        end
      end else begin
        if (clr)       last_fall[i] = 0;
        else if (pre)  last_fall[i] = 1;
        else if (en)   last_fall[i] = d;
      end
    end
    model_force();
  endtask

  function automatic string tag_for(int i, bit rising);
    if (clr) return en ? "R3" : "R10";
    if (pre) return en ? "R4" : "R10";
    if (!en) return "R5";
    if (mode[i] == 1) return "R8";
    if (mode[i] == 2) return "R9";
    return rising ? "R1" : "R2";
  endfunction

  task automatic check_one(int i, string tag);
    checks++;
    if (q1[i] !== exp_q1(i) || q2[i] !== exp_q2(i)) begin
      errors++;
      $display("FAIL %s inst%0d t=%0t: q_rise=%b q_fall=%b expected %b %b",
               tag, i, $time, q1[i], q2[i], exp_q1(i), exp_q2(i));
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit rising;
    for (int i = 0; i < 4; i++) begin
      last_rise[i] = init1[i]; rise_prev[i] = init1[i];
      last_fall[i] = init2[i]; fall_seen[i] = init2[i];
    end
    #1;
    for (int i = 0; i < 4; i++) check_one(i, "R7");
    #5;
    clr = 1'b1;
    for (int k = 0; k < 1600; k++) begin
      @(clk);
      rising = clk;
      #1 model_edge(rising);
      #1;
      for (int i = 0; i < 4; i++) check_one(i, tag_for(i, rising));
      #3;
      d = 1'($urandom);
      if ((k >= 400 && k < 520) || (k >= 900 && k < 1000)) en = ($urandom % 4 == 0);
      else en = ($urandom % 8 != 0);
      if (rising) begin
        int unsigned pick;
        bit nc;
        bit np;
        pick = (k >= 800 && k < 1000) ? $urandom % 4 : $urandom % 12;
        nc = (k < 6) || pick == 0 || pick == 2;
        np = pick == 1 || pick == 2;
        if (clr && np && !nc) np = 1'b0;
        clr = nc;
        pre = np;
      end
      #1 model_force();
      // R6: asynchronous instances react before any edge, synchronous ones wait
      if (clr || pre)
        for (int i = 0; i < 4; i++) check_one(i, "R6");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule